// File: doc/BRIEF.md
# Stored Sequence Stimulus Generator

This block replays a fixed list of samples onto a data bus, one sample per clock cycle, beginning with entry 0 as soon as synchronous reset is released. The block computes the list at elaboration from a small set of parameters: the number of entries, a start value, a step, and a pattern kind. Each entry is a plain arithmetic progression or its binary-reflected Gray code, truncated to the bus width. The block is meant to feed a device under test inside a testbench that is itself synthesizable.

The block never wraps or stops. After it has presented every entry, the bus keeps the final entry for as long as reset stays low. A synchronous reset at any time restarts playback from entry 0.

Top module: `stim_seq_gen`

## Requirements
- R1: While reset is high, and in the first cycle after reset falls, the bus carries entry 0.
- R2: Entries appear strictly in index order. Each rising clock edge with reset low moves the bus from entry i to entry i+1.
- R3: When the bus reaches entry LENGTH-1, it holds that value on every later cycle until reset is asserted. The internal index saturates and never wraps.
- R4: A reset asserted partway through playback returns the bus to entry 0 at the next rising edge.
- R5: With pattern kind 0 (arithmetic), entry i equals (START + STEP*i) modulo 2^DATA_W.
- R6: With pattern kind 1 (Gray), entry i equals a XOR (a >> 1), where a is the arithmetic value from R5 before truncation to DATA_W.
- R7: With LENGTH = 1, the bus carries entry 0 constantly, before and after reset. The index register is then one bit wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. One sample is presented per cycle. |
| rst | input | 1 | Synchronous reset, active high. Restarts playback at entry 0. |
| data_out | output | DATA_W | Current sample of the stored sequence. |

## Verification
A corrupted index shows up on the bus in the same cycle, because the output is a pure decode of the index register. A skipped, repeated or out-of-order entry therefore differs from the expected progression at the first sample after the fault. If the saturation logic fails, the bus wraps back to an early entry or moves away from the final entry. The bench detects this one cycle after the final entry first appears, because it keeps sampling well past the end of the table. A reset that fails to clear the index shows up at the first sample after the reset edge.

// File: rtl/stim_pkg.sv
package stim_pkg;

    typedef enum logic [0:0] {
        PAT_ARITH = 1'b0,
        PAT_GRAY  = 1'b1
    } pattern_e;

    typedef logic [63:0] wide_t;

    function automatic wide_t arith_value(wide_t start, wide_t step, wide_t idx);
        return start + step * idx;
    endfunction

    function automatic wide_t to_gray(wide_t v);
        return v ^ (v >> 1);
    endfunction

    function automatic wide_t sample_value(pattern_e kind, wide_t start,
                                           wide_t step, wide_t idx);
        wide_t a;
        a = arith_value(start, step, idx);
        return (kind == PAT_GRAY) ? to_gray(a) : a;
    endfunction

    function automatic int index_width(int length);
        return (length > 1) ? $clog2(length) : 1;
    endfunction

endpackage

// File: rtl/stim_index_ctr.sv
module stim_index_ctr #(
    parameter int LENGTH = 11,
    parameter int IDX_W  = stim_pkg::index_width(LENGTH)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LENGTH - 1);

    logic at_end;
    assign at_end = (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (!at_end) begin
            idx <= idx + 1'b1;
        end
    end

    // R3
    idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST);

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (idx == LAST) |=> (idx == LAST));

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (idx != LAST) |=> (idx == $past(idx) + 1'b1));

    // R4
    idx_clear_chk: assert property (@(posedge clk)
        rst |=> (idx == '0));

endmodule

// File: rtl/stim_table_rom.sv
module stim_table_rom #(
    parameter int                 DATA_W = 8,
    parameter int                 LENGTH = 11,
    parameter int                 IDX_W  = stim_pkg::index_width(LENGTH),
    parameter stim_pkg::pattern_e KIND   = stim_pkg::PAT_ARITH,
    parameter logic [63:0]        START  = 64'd1,
    parameter logic [63:0]        STEP   = 64'd2
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] entries [LENGTH];

    for (genvar g = 0; g < LENGTH; g++) begin : g_entry
        assign entries[g] = DATA_W'(stim_pkg::sample_value(KIND, START, STEP, 64'(g)));
    end

    always_comb begin
        data = entries[LENGTH-1];
        for (int i = 0; i < LENGTH; i++) begin
            if (idx == IDX_W'(i)) data = entries[i];
        end
    end

endmodule

// File: rtl/stim_seq_gen.sv
module stim_seq_gen #(
    parameter int                 DATA_W = 8,
    parameter int                 LENGTH = 11,
    parameter stim_pkg::pattern_e KIND   = stim_pkg::PAT_ARITH,
    parameter logic [63:0]        START  = 64'd1,
    parameter logic [63:0]        STEP   = 64'd2
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] data_out
);
    localparam int IDX_W = stim_pkg::index_width(LENGTH);

    initial begin
        if (LENGTH < 1)  $error("LENGTH must be at least 1");
        if (DATA_W < 1 || DATA_W > 64) $error("DATA_W must be 1..64");
    end

    logic [IDX_W-1:0] idx;

    stim_index_ctr #(
        .LENGTH (LENGTH),
        .IDX_W  (IDX_W)
    ) u_ctr (
        .clk (clk),
        .rst (rst),
        .idx (idx)
    );

    stim_table_rom #(
        .DATA_W (DATA_W),
        .LENGTH (LENGTH),
        .IDX_W  (IDX_W),
        .KIND   (KIND),
        .START  (START),
        .STEP   (STEP)
    ) u_rom (
        .idx  (idx),
        .data (data_out)
    );

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (idx == IDX_W'(LENGTH - 1)) |=> $stable(data_out));

endmodule

// File: tb/stim_seq_gen_test.sv
`timescale 1ns/1ps
module stim_seq_gen_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] out_a;
    logic [3:0] out_g;
    logic [7:0] out_s;

    stim_seq_gen #(.DATA_W(8), .LENGTH(11), .KIND(stim_pkg::PAT_ARITH),
                   .START(64'd1), .STEP(64'd2))
        uut (.clk(clk), .rst(rst), .data_out(out_a));

    stim_seq_gen #(.DATA_W(4), .LENGTH(6), .KIND(stim_pkg::PAT_GRAY),
                   .START(64'd3), .STEP(64'd5))
        uut_gray (.clk(clk), .rst(rst), .data_out(out_g));

    stim_seq_gen #(.DATA_W(8), .LENGTH(1), .KIND(stim_pkg::PAT_ARITH),
                   .START(64'hA5), .STEP(64'd7))
        uut_one (.clk(clk), .rst(rst), .data_out(out_s));

    function automatic logic [7:0] exp_a(int k);
        int i = (k > 10) ? 10 : k;
        return 8'(1 + 2 * i);
    endfunction

    function automatic logic [3:0] exp_g(int k);
        int i = (k > 5) ? 5 : k;
        int a = 3 + 5 * i;
        return 4'(a ^ (a >> 1));
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req, int k);
        check({req, " arith"}, 64'(out_a), 64'(exp_a(k)));
        check({req, " gray"},  64'(out_g), 64'(exp_g(k)));
        check("R7 single", 64'(out_s), 64'hA5);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: during reset
        repeat (3) @(negedge clk);
        check_all("R1 in reset", 0);
        rst = 1'b0;
        // R1 first cycle, R2/R5/R6 progression, R3 hold long past end
        for (int k = 0; k < 20; k++) begin
            check_all((k == 0) ? "R1 first" : ((k <= 10) ? "R2 R5 R6 step" : "R3 hold"), k);
            @(negedge clk);
        end
        // R4: reset while saturated
        rst = 1'b1;
        @(negedge clk);
        check_all("R4 after hold", 0);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check_all("R2 replay", k);
            @(negedge clk);
        end
        // R4: reset partway (bus now at entry 4)
        check_all("R2 mid", 4);
        rst = 1'b1;
        @(negedge clk);
        check_all("R4 mid", 0);
        @(negedge clk);
        check_all("R4 held", 0);
        rst = 1'b0;
        for (int k = 0; k < 14; k++) begin
            check_all((k <= 10) ? "R2 rerun" : "R3 rerun", k);
            @(negedge clk);
        end
        finish_run();
    end
endmodule